// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives a single PWM output. An 8-bit period value sets the cycle length and a 10-bit duty value sets the high time. The time base is an 8-bit timer with a 2-bit sub-count below it. The sub-count advances on every clock-enable tick, and the timer steps each time the sub-count wraps, so the two together form a 10-bit counter. A cycle ends on the last sub-count of the tick in which the timer equals the period value. At that point the time base restarts from zero, the output rises, and a one-cycle period-match pulse is sent out for any postscaler or interrupt logic outside the block.

Software writes the duty value into a master register. The upper 8 bits have their own write strobe. The lower 2 bits share a control byte with the mode field. The duty comparator never reads the master value. It reads a slave copy that is refreshed only at a cycle boundary, so a write made in the middle of a cycle cannot cut that cycle short or stretch it. A control byte whose mode field is not "PWM" stops the generator and pulls the output low at once.

Top module: `pwm_db10`

## Requirements
- R1: After reset, `pwmOut` and `periodMatch` are 0 and stay 0 while no control byte with the mode field set has been written.
- R2: The duty value is `{duty-high byte, control[5:4]}`. Control bits 3:2 both set to 1 select PWM mode. Any other value in those bits selects stop.
- R3: With a tick on every clock, a cycle with period value P lasts exactly (P+1)*4 ticks. The interval between two consecutive `periodMatch` pulses equals that length.
- R4: For a duty value D below the cycle length, `pwmOut` is high for exactly D ticks, starting at the cycle boundary. It falls when the 10-bit time base reaches D.
- R5: A duty write made during a cycle does not change that cycle's high time. It takes effect from the next cycle.
- R6: A duty value equal to or greater than the cycle length keeps `pwmOut` high for the whole cycle.
- R7: A duty value of 0 keeps `pwmOut` low for the whole cycle.
- R8: A control write that selects stop drives `pwmOut` low in the following cycle. No further `periodMatch` pulses occur while stopped.
- R9: `periodMatch` is high for exactly one clock cycle per cycle boundary.
- R10: While `tick` is low, neither `pwmOut` nor the time base advances and no `periodMatch` pulse occurs. With a tick on every second clock, the cycle and the high time both double when measured in clocks.
- R11: After PWM mode is selected, the first tick starts a cycle and raises `pwmOut`. No pulse is sent for that start, so the first `periodMatch` arrives (P+1)*4 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable for the time base |
| wrPeriod | input | 1 | Write `wrData` into the period register |
| wrDutyHi | input | 1 | Write `wrData` into the upper duty bits |
| wrCtrl | input | 1 | Write `wrData` into the control byte (mode 3:2, duty low 5:4) |
| wrData | input | 8 | Write data shared by the three register strobes |
| pwmOut | output | 1 | PWM output |
| periodMatch | output | 1 | One-cycle pulse at each cycle boundary |

## Verification
The single-cycle pulse property depends on the cycle being at least four ticks long. The timer-plus-sub-count structure guarantees this for any period value, and the stimulus does not try to defeat it. The freeze property assumes that only the control write can move the output outside a tick, so it is gated on both `tick` and `wrCtrl` being low. The slave-hold property assumes that the duty copy changes only at a boundary or at a start. The bench keeps within these assumptions: it drives every input on the falling clock edge and issues one register write at a time. It also changes the tick pattern only between checked windows or in an explicit freeze test.

// File: rtl/pwm_db10_pkg.sv
package pwm_db10_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic stop;   // hold time base at zero, output low
    logic start;  // first cycle after mode select
    logic wrap;   // cycle boundary reached
    logic inc;    // ordinary tick
  } pwmStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} pwmState_t;

  localparam logic [1:0] MODE_PWM = 2'b11;

endpackage

// File: rtl/pwm_db10_ctrl.sv
module pwm_db10_ctrl
  import pwm_db10_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wrCtrl,
  input  logic [1:0] wrMode,
  input  logic       modeOn,
  input  logic       periodEnd,
  output pwmStrobe_t strobe,
  output logic       running
);

  pwmState_t state, stateNext;
  logic      wrOff;

  assign wrOff   = wrCtrl && (wrMode != MODE_PWM);
  assign running = (state == ST_RUN);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (wrOff || !modeOn) begin
      strobe.stop = 1'b1;
      stateNext   = ST_IDLE;
    end else if (state == ST_IDLE) begin
      if (tick) begin
        strobe.start = 1'b1;
        stateNext    = ST_RUN;
      end
    end else if (tick) begin
      if (periodEnd) strobe.wrap = 1'b1;
      else           strobe.inc  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/pwm_db10_dp.sv
module pwm_db10_dp
  import pwm_db10_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int LO_POS = 4,
  localparam int BASE_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrPeriod,
  input  logic              wrDutyHi,
  input  logic              wrCtrl,
  input  logic [TMR_W-1:0]  wrData,
  input  pwmStrobe_t        strobe,
  output logic              modeOn,
  output logic              periodEnd,
  output logic [BASE_W-1:0] dutyActive,
  output logic              pwmOut,
  output logic              periodMatch
);

  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic [TMR_W-1:0]  periodReg, dutyHiReg, tmrReg, tmrNext;
  logic [SUB_W-1:0]  dutyLoReg, subReg, subNext;
  logic [1:0]        modeReg;
  logic [BASE_W-1:0] masterDuty, slaveDuty, baseNext;
  logic              outReg, matchReg;

  assign masterDuty = {dutyHiReg, dutyLoReg};
  assign modeOn     = (modeReg == MODE_PWM);
  assign periodEnd  = (tmrReg == periodReg) && (subReg == SUB_LAST);

  // Sub-count wraps into the timer
  always_comb begin
    subNext = subReg + 1'b1;
    tmrNext = (subReg == SUB_LAST) ? tmrReg + 1'b1 : tmrReg;
  end
  assign baseNext = {tmrNext, subNext};

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodReg <= '0;
      dutyHiReg <= '0;
      dutyLoReg <= '0;
      modeReg   <= '0;
    end else begin
      if (wrPeriod) periodReg <= wrData;
      if (wrDutyHi) dutyHiReg <= wrData;
      if (wrCtrl) begin
        modeReg   <= wrData[3:2];
        dutyLoReg <= wrData[LO_POS+SUB_W-1:LO_POS];
      end
    end
  end

  // Time base, slave duty, output latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrReg    <= '0;
      subReg    <= '0;
      slaveDuty <= '0;
      outReg    <= 1'b0;
      matchReg  <= 1'b0;
    end else begin
      matchReg <= strobe.wrap;
      if (strobe.stop) begin
        tmrReg <= '0;
        subReg <= '0;
        outReg <= 1'b0;
      end else if (strobe.start || strobe.wrap) begin
        tmrReg    <= '0;
        subReg    <= '0;
        slaveDuty <= masterDuty;
        outReg    <= (masterDuty != '0);  // clear wins at zero duty
      end else if (strobe.inc) begin
        tmrReg <= tmrNext;
        subReg <= subNext;
        if (baseNext == slaveDuty) outReg <= 1'b0;
      end
    end
  end

  assign dutyActive  = slaveDuty;
  assign pwmOut      = outReg;
  assign periodMatch = matchReg;

endmodule

// File: rtl/pwm_db10.sv
module pwm_db10
  import pwm_db10_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrPeriod,
  input  logic             wrDutyHi,
  input  logic             wrCtrl,
  input  logic [TMR_W-1:0] wrData,
  output logic             pwmOut,
  output logic             periodMatch
);

  localparam int BASE_W = TMR_W + SUB_W;

  pwmStrobe_t        strobe;
  logic              modeOn, periodEnd, running;
  logic [BASE_W-1:0] dutyActive;

  pwm_db10_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wrCtrl   (wrCtrl),
    .wrMode   (wrData[3:2]),
    .modeOn   (modeOn),
    .periodEnd(periodEnd),
    .strobe   (strobe),
    .running  (running)
  );

  pwm_db10_dp #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrPeriod   (wrPeriod),
    .wrDutyHi   (wrDutyHi),
    .wrCtrl     (wrCtrl),
    .wrData     (wrData),
    .strobe     (strobe),
    .modeOn     (modeOn),
    .periodEnd  (periodEnd),
    .dutyActive (dutyActive),
    .pwmOut     (pwmOut),
    .periodMatch(periodMatch)
  );

endmodule

// File: rtl/pwm_db10_chk.sv
module pwm_db10_chk #(
  parameter int BASE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wrCtrl,
  input logic [1:0]        wrMode,
  input logic              pwmOut,
  input logic              periodMatch,
  input logic [BASE_W-1:0] dutyActive,
  input logic              running
);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    periodMatch |=> !periodMatch);

  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCtrl && wrMode != 2'b11) |=> !pwmOut);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wrCtrl) |=> ($stable(pwmOut) && !periodMatch));

  p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dutyActive == '0) |-> !pwmOut);

  p_slave_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dutyActive) |-> (periodMatch || $rose(running)));

  p_boundary_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (periodMatch && dutyActive != '0) |-> pwmOut);

endmodule

bind pwm_db10 pwm_db10_chk #(.BASE_W(BASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wrCtrl     (wrCtrl),
  .wrMode     (wrData[3:2]),
  .pwmOut     (pwmOut),
  .periodMatch(periodMatch),
  .dutyActive (dutyActive),
  .running    (running)
);

// File: tb/pwm_db10_tb.sv
module pwm_db10_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wrPeriod = 1'b0, wrDutyHi = 1'b0, wrCtrl = 1'b0;
  logic [7:0] wrData = '0;
  logic       pwmOut, periodMatch;

  int nChk = 0, nBad = 0, tickMode = 1;

  always #10 clk = ~clk;  // 50 MHz

  pwm_db10 u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wrPeriod(wrPeriod), .wrDutyHi(wrDutyHi), .wrCtrl(wrCtrl),
    .wrData(wrData), .pwmOut(pwmOut), .periodMatch(periodMatch)
  );

  // {period, dutyHi, dutyLo, tickMode}
  localparam logic [31:0] VEC [7] = '{
    {8'd3, 8'd2, 8'd1, 8'd1},
    {8'd0, 8'd0, 8'd2, 8'd1},
    {8'd9, 8'd0, 8'd0, 8'd1},
    {8'd2, 8'd5, 8'd0, 8'd1},
    {8'd2, 8'd3, 8'd0, 8'd1},
    {8'd4, 8'd3, 8'd3, 8'd2},
    {8'd7, 8'd7, 8'd0, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (tickMode == 0)      tick = 1'b0;
    else if (tickMode == 1) tick = 1'b1;
    else                    tick = ~tick;
  endtask

  task automatic wrReg(input int which, input logic [7:0] d);
    wrData = d;
    wrPeriod = (which == 0);
    wrDutyHi = (which == 1);
    wrCtrl   = (which == 2);
    cyc();
    wrPeriod = 1'b0; wrDutyHi = 1'b0; wrCtrl = 1'b0;
  endtask

  task automatic measure(input int writeAt, input logic [7:0] wVal,
                         output int len, output int hi);
    int g = 0;
    while (!periodMatch && g < 3000) begin cyc(); g++; end
    len = 0; hi = 0;
    do begin
      if (pwmOut) hi++;
      if (len == writeAt) begin wrDutyHi = 1'b1; wrData = wVal; end
      cyc();
      wrDutyHi = 1'b0;
      len++;
    end while (!periodMatch && len < 3000);
  endtask

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int len, hi, c;
    bit ok;
    repeat (3) cyc();
    rst_n = 1'b1;
    // R1: reset state
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (pwmOut || periodMatch) ok = 0;
    end
    chk(ok && !pwmOut, "R1", pwmOut, 0);
    chk(!periodMatch, "R1", periodMatch, 0);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      int p, d, lo, cl, expHi, div;
      p = VEC[v][31:24]; lo = VEC[v][15:8]; div = VEC[v][7:0];
      d = VEC[v][23:16] * 4 + lo;
      cl = (p + 1) * 4;
      expHi = (d < cl) ? d : cl;
      wrReg(2, 8'h00);
      tickMode = div;
      wrReg(0, 8'(p));
      wrReg(1, VEC[v][23:16]);
      wrReg(2, {2'b00, lo[1:0], 4'b1100});
      measure(-1, 8'h00, len, hi);
      if (div == 2) chk(len == cl * 2, "R10", len, cl * 2);
      else          chk(len == cl, "R3", len, cl);
      if (div == 2)      chk(hi == expHi * 2, "R10", hi, expHi * 2);
      else if (d == 0)   chk(hi == 0, "R7", hi, 0);
      else if (d >= cl)  chk(hi == cl, "R6", hi, cl);
      else if (lo != 0)  chk(hi == expHi, "R2", hi, expHi);
      else               chk(hi == expHi, "R4", hi, expHi);
    end

    // R5: mid-cycle duty write applies next cycle
    wrReg(2, 8'h00);
    tickMode = 1;
    wrReg(0, 8'd3);
    wrReg(1, 8'd1);
    wrReg(2, 8'b0000_1100);
    measure(-1, 8'h00, len, hi);
    chk(hi == 4, "R5", hi, 4);
    measure(3, 8'd3, len, hi);
    chk(hi == 4, "R5", hi, 4);
    measure(-1, 8'h00, len, hi);
    chk(hi == 12, "R5", hi, 12);

    // R10: freeze with tick held low
    tickMode = 0;
    cyc();
    ok = 1;
    for (int i = 0; i < 50; i++) begin
      cyc();
      if (!pwmOut || periodMatch) ok = 0;
    end
    chk(ok, "R10", pwmOut, 1);
    tickMode = 1;
    measure(-1, 8'h00, len, hi);
    measure(-1, 8'h00, len, hi);
    chk(len == 16 && hi == 12, "R10", len, 16);

    // R8: stop write forces low, no pulses
    chk(pwmOut == 1'b1, "R8", pwmOut, 1);
    wrReg(2, 8'b0011_0000);
    chk(pwmOut == 1'b0, "R8", pwmOut, 0);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (pwmOut || periodMatch) ok = 0;
    end
    chk(ok, "R8", pwmOut, 0);

    // R11: start without pulse; R9 single-cycle pulse
    wrReg(0, 8'd1);
    wrReg(1, 8'd0);
    wrReg(2, 8'b0011_1100);
    chk(pwmOut == 1'b0, "R11", pwmOut, 0);
    c = 0;
    cyc(); c++;
    chk(pwmOut == 1'b1, "R11", pwmOut, 1);
    while (!periodMatch && c < 3000) begin cyc(); c++; end
    chk(c == 9, "R11", c, 9);
    cyc();
    chk(periodMatch == 1'b0, "R9", periodMatch, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule